// File: doc/BRIEF.md
# ECC-Protected SRAM Controller with Sub-Word Read-Modify-Write

This block is a bus slave placed in front of a single-port SRAM array. Each stored row is a 39-bit codeword: 32 data bits and 7 check bits. The check bits are computed from the data and from the word address, so a row that is returned from the wrong location is caught as well as a flipped bit. On every read the codeword is checked. A single flipped bit is repaired before the data is returned. A double flip, or an address mismatch, is reported with an error response and a fault line toward the system fault collector. The first such failure is also captured locally until it is cleared.

Requests arrive on a valid/ready channel. A request transfers on a rising edge where both `req_valid` and `req_ready` are high. The requester must hold all request fields stable while `req_valid` is high and `req_ready` is low. `req_ready` is low only while a multi-cycle operation is under way. The response channel carries no back-pressure: `rsp_valid` is a one-cycle pulse, and the requester must take it in that cycle.

Full-word writes go straight to the array. A doubleword write becomes two consecutive word writes. A byte or halfword write reads the row, corrects it, merges the new lanes, re-encodes and writes the row back. A test mask is XORed into every codeword on its way to the array, so single-bit and double-bit faults can be planted on purpose.

Top module: `ecc_sram_ctrl`

## Requirements
- R1: A codeword stores data in bits 31:0 and check bits in bits 38:32. A word write (`req_size`=2) writes its row in the cycle it is accepted. `rsp_valid` rises one cycle later, and `req_ready` stays high, so writes can run back to back.
- R2: A read writes nothing and ignores `req_size` and `req_addr[1:0]`. It returns the whole word at `req_addr[AW-1:2]`. `req_ready` is low for the one cycle after acceptance, and `rsp_valid` comes two cycles after acceptance.
- R3: A doubleword write (`req_size`=3) puts `req_wdata[31:0]` into the even word of the aligned pair and `req_wdata[63:32]` into the odd word. `req_ready` is low for one cycle, and the response comes two cycles after acceptance.
- R4: A byte write (`req_size`=0) takes lane `req_addr[1:0]` of `req_wdata`, where lane n is bits 8n+7:8n. A halfword write (`req_size`=1) takes lanes 2·`req_addr[1]` and 2·`req_addr[1]`+1. All other bytes of the word are kept. `req_ready` is low for one cycle, and the response comes two cycles after acceptance.
- R5: A single flipped bit, in either the data field or the check field, is corrected. The corrected data is returned with `rsp_err`=0, and `ce_pulse` is high in the response cycle.
- R6: A double-bit error is uncorrectable. So is a codeword that was stored at a word address differing in one bit from the one being read. In either case `rsp_err`, `ue_pulse` and `fault_out` are high in the response cycle, and `rsp_rdata` carries the raw stored data bits.
- R7: If the read phase of a byte or halfword write finds an uncorrectable error, no write-back takes place, the row keeps its contents, and the response has `rsp_err`=1.
- R8: If the read phase of a byte or halfword write finds a correctable error, the corrected word is merged and written back. The response has `rsp_err`=0 and `ce_pulse`=1, and a later read of the row is clean.
- R9: The first uncorrectable error sets `err_valid` and captures the byte address of the failing word and its syndrome. Both are held, and later failures are ignored, until `err_clear`. An `err_clear` in the same cycle as a new failure captures the new failure.
- R10: `inj_mask` is XORed into every codeword written to the array.
- R11: Out of reset `req_ready` is 1, and `rsp_valid`, `ce_pulse`, `ue_pulse`, `fault_out` and `err_valid` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request can be taken this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_size | input | 2 | 0 byte, 1 halfword, 2 word, 3 doubleword |
| req_addr | input | AW | Byte address |
| req_wdata | input | 64 | Write data, byte lane n in bits 8n+7:8n |
| rsp_valid | output | 1 | One-cycle response strobe |
| rsp_rdata | output | 32 | Read data (zero for writes) |
| rsp_err | output | 1 | Uncorrectable error in this access |
| mem_en | output | 1 | Array access enable |
| mem_we | output | 1 | Array write enable |
| mem_addr | output | AW-2 | Array word index |
| mem_wdata | output | 39 | Codeword to store |
| mem_rdata | input | 39 | Codeword read, valid one cycle after a read enable |
| inj_mask | input | 39 | Bits to flip in written codewords |
| ce_pulse | output | 1 | Corrected error seen |
| ue_pulse | output | 1 | Uncorrectable error seen |
| fault_out | output | 1 | Fault line to the system collector |
| err_clear | input | 1 | Clears the captured failure |
| err_valid | output | 1 | A failure is captured |
| err_addr | output | AW | Byte address of the captured failing word |
| err_syndrome | output | 7 | Syndrome of the captured failure |

## Verification
Two functions can fall in one cycle: error correction and lane merging inside a sub-word write, and failure capture together with a clear. The first case is provoked by planting a single flipped bit in a row and then writing one byte of it. The response must show a correctable error with no error flag, and a following read must return the merged word with no error at all. The second case is provoked by raising `err_clear` in exactly the cycle in which a read of an address-mismatched row reports its failure. The captured address must then name the new row and not the one held before.

// File: rtl/ecc_sram_pkg.sv
package ecc_sram_pkg;
  localparam int DW  = 32;
  localparam int CW  = 7;
  localparam int CWW = DW + CW;
  localparam int NB  = DW / 8;

  typedef enum logic [1:0] {SZ_BYTE, SZ_HALF, SZ_WORD, SZ_DWORD} size_e;
  typedef enum logic [1:0] {ST_IDLE, ST_RD, ST_WR2, ST_MRG} state_e;

  // n-th nonzero CW-bit column of the given weight, in ascending order
  function automatic logic [CW-1:0] nth_col(input int n, input int w);
    logic [CW-1:0] res;
    logic [CW-1:0] c;
    int k;
    res = '0;
    k = 0;
    for (int v = 1; v < (1 << CW); v++) begin
      c = CW'(v);
      if ($countones(c) == w) begin
        if (k == n) res = c;
        k++;
      end
    end
    return res;
  endfunction

  // data bits use weight-3 columns (odd: single flips are locatable)
  function automatic logic [CW-1:0] data_col(input int i);
    return nth_col(i, 3);
  endfunction

  // address bits use weight-2 columns (even: a mismatch looks like a double error)
  function automatic logic [CW-1:0] addr_col(input int k);
    return nth_col(k % 21, 2);
  endfunction

  function automatic logic [DW-1:0] row_dmask(input int r);
    logic [DW-1:0] m;
    logic [CW-1:0] c;
    for (int i = 0; i < DW; i++) begin
      c = data_col(i);
      m[i] = c[r];
    end
    return m;
  endfunction

  function automatic logic [31:0] row_amask(input int r);
    logic [31:0] m;
    logic [CW-1:0] c;
    for (int k = 0; k < 32; k++) begin
      c = addr_col(k);
      m[k] = c[r];
    end
    return m;
  endfunction
endpackage

// File: rtl/ecc_encoder.sv
module ecc_encoder
  import ecc_sram_pkg::*;
#(
  parameter int IW = 10
) (
  input  logic [DW-1:0] data,
  input  logic [IW-1:0] idx,
  output logic [CW-1:0] chk
);
  for (genvar r = 0; r < CW; r++) begin : g_row
    localparam logic [DW-1:0] DM = row_dmask(r);
    localparam logic [31:0]   AM = row_amask(r);
    assign chk[r] = (^(data & DM)) ^ (^(idx & AM[IW-1:0]));
  end
endmodule

// File: rtl/ecc_decoder.sv
module ecc_decoder
  import ecc_sram_pkg::*;
#(
  parameter int IW = 10
) (
  input  logic [CWW-1:0] cw,
  input  logic [IW-1:0]  idx,
  output logic [DW-1:0]  data_fix,
  output logic [CW-1:0]  syn,
  output logic           ce,
  output logic           ue
);
  logic [CW-1:0] calc;
  logic [DW-1:0] hit;
  logic          odd;
  logic          chk_hit;

  ecc_encoder #(.IW(IW)) u_enc (
    .data (cw[DW-1:0]),
    .idx  (idx),
    .chk  (calc)
  );

  assign syn = calc ^ cw[CWW-1:DW];

  for (genvar i = 0; i < DW; i++) begin : g_hit
    localparam logic [CW-1:0] COL = data_col(i);
    assign hit[i] = (syn == COL);
  end

  assign odd      = ^syn;
  assign chk_hit  = $onehot(syn);
  assign ce       = odd && ((|hit) || chk_hit);
  assign ue       = (syn != '0) && !ce;
  assign data_fix = cw[DW-1:0] ^ hit;
endmodule

// File: rtl/ecc_lane_merge.sv
module ecc_lane_merge
  import ecc_sram_pkg::*;
(
  input  logic [DW-1:0] old_w,
  input  logic [DW-1:0] new_w,
  input  logic [NB-1:0] be,
  output logic [DW-1:0] merged
);
  for (genvar b = 0; b < NB; b++) begin : g_lane
    assign merged[8*b +: 8] = be[b] ? new_w[8*b +: 8] : old_w[8*b +: 8];
  end
endmodule

// File: rtl/ecc_err_capture.sv
module ecc_err_capture
  import ecc_sram_pkg::*;
#(
  parameter int IW = 10
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ue_evt,
  input  logic [IW-1:0] evt_idx,
  input  logic [CW-1:0] evt_syn,
  input  logic          clr,
  output logic          err_valid,
  output logic [IW-1:0] err_idx,
  output logic [CW-1:0] err_syn
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      err_valid <= 1'b0;
      err_idx   <= '0;
      err_syn   <= '0;
    end else if (ue_evt && (!err_valid || clr)) begin
      err_valid <= 1'b1;
      err_idx   <= evt_idx;
      err_syn   <= evt_syn;
    end else if (clr) begin
      err_valid <= 1'b0;
    end
  end

  // R9: captured failure is held until cleared
  p_hold_until_clear_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (err_valid && !clr) |=> (err_valid && $stable(err_idx) && $stable(err_syn)));

  // R9: clear coinciding with a new failure keeps the new one
  p_clear_and_capture_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (ue_evt && clr) |=> (err_valid && err_idx == $past(evt_idx)));
endmodule

// File: rtl/ecc_sram_ctrl.sv
module ecc_sram_ctrl
  import ecc_sram_pkg::*;
#(
  parameter int AW = 12
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                req_valid,
  output logic                req_ready,
  input  logic                req_write,
  input  logic [1:0]          req_size,
  input  logic [AW-1:0]       req_addr,
  input  logic [2*DW-1:0]     req_wdata,
  output logic                rsp_valid,
  output logic [DW-1:0]       rsp_rdata,
  output logic                rsp_err,
  output logic                mem_en,
  output logic                mem_we,
  output logic [AW-3:0]       mem_addr,
  output logic [CWW-1:0]      mem_wdata,
  input  logic [CWW-1:0]      mem_rdata,
  input  logic [CWW-1:0]      inj_mask,
  output logic                ce_pulse,
  output logic                ue_pulse,
  output logic                fault_out,
  input  logic                err_clear,
  output logic                err_valid,
  output logic [AW-1:0]       err_addr,
  output logic [CW-1:0]       err_syndrome
);
  localparam int IW = AW - 2;

  state_e        st;
  size_e         sz;
  logic          acc;
  logic [IW-1:0] req_idx;
  logic [NB-1:0] req_be;
  logic [IW-1:0] idx_q;
  logic [DW-1:0] wd_q;
  logic [NB-1:0] be_q;

  logic [DW-1:0] enc_data;
  logic [IW-1:0] enc_idx;
  logic [CW-1:0] enc_chk;
  logic [DW-1:0] dec_fix;
  logic [CW-1:0] dec_syn;
  logic          dec_ce;
  logic          dec_ue;
  logic [DW-1:0] merged;
  logic [IW-1:0] cap_idx;
  logic          ue_evt;

  assign sz        = size_e'(req_size);
  assign req_ready = (st == ST_IDLE);
  assign acc       = req_valid && req_ready;
  assign req_idx   = req_addr[AW-1:2];

  always_comb begin
    case (sz)
      SZ_BYTE: req_be = NB'(1) << req_addr[1:0];
      SZ_HALF: req_be = req_addr[1] ? 4'b1100 : 4'b0011;
      default: req_be = '1;
    endcase
  end

  ecc_encoder #(.IW(IW)) u_wr_enc (
    .data (enc_data),
    .idx  (enc_idx),
    .chk  (enc_chk)
  );

  ecc_decoder #(.IW(IW)) u_rd_dec (
    .cw       (mem_rdata),
    .idx      (idx_q),
    .data_fix (dec_fix),
    .syn      (dec_syn),
    .ce       (dec_ce),
    .ue       (dec_ue)
  );

  ecc_lane_merge u_merge (
    .old_w  (dec_fix),
    .new_w  (wd_q),
    .be     (be_q),
    .merged (merged)
  );

  // array port control
  always_comb begin
    mem_en   = 1'b0;
    mem_we   = 1'b0;
    mem_addr = req_idx;
    enc_data = req_wdata[DW-1:0];
    enc_idx  = req_idx;
    case (st)
      ST_IDLE: begin
        if (acc) begin
          mem_en = 1'b1;
          if (req_write && sz == SZ_WORD) begin
            mem_we = 1'b1;
          end else if (req_write && sz == SZ_DWORD) begin
            mem_we   = 1'b1;
            mem_addr = {req_idx[IW-1:1], 1'b0};
            enc_idx  = {req_idx[IW-1:1], 1'b0};
          end
        end
      end
      ST_WR2: begin
        mem_en   = 1'b1;
        mem_we   = 1'b1;
        mem_addr = idx_q;
        enc_data = wd_q;
        enc_idx  = idx_q;
      end
      ST_MRG: begin
        if (!dec_ue) begin
          mem_en   = 1'b1;
          mem_we   = 1'b1;
          mem_addr = idx_q;
          enc_data = merged;
          enc_idx  = idx_q;
        end
      end
      default: ;
    endcase
  end

  assign mem_wdata = {enc_chk, enc_data} ^ inj_mask;

  // sequencing and request capture
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st    <= ST_IDLE;
      idx_q <= '0;
      wd_q  <= '0;
      be_q  <= '0;
    end else begin
      case (st)
        ST_IDLE: begin
          if (acc) begin
            idx_q <= req_idx;
            wd_q  <= req_wdata[DW-1:0];
            be_q  <= req_be;
            if (!req_write) begin
              st <= ST_RD;
            end else if (sz == SZ_DWORD) begin
              st    <= ST_WR2;
              idx_q <= {req_idx[IW-1:1], 1'b1};
              wd_q  <= req_wdata[2*DW-1:DW];
            end else if (sz != SZ_WORD) begin
              st <= ST_MRG;
            end
          end
        end
        default: st <= ST_IDLE;
      endcase
    end
  end

  // response and error strobes
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_rdata <= '0;
      rsp_err   <= 1'b0;
      ce_pulse  <= 1'b0;
      ue_pulse  <= 1'b0;
    end else begin
      rsp_valid <= 1'b0;
      rsp_rdata <= '0;
      rsp_err   <= 1'b0;
      ce_pulse  <= 1'b0;
      ue_pulse  <= 1'b0;
      case (st)
        ST_IDLE: begin
          if (acc && req_write && sz == SZ_WORD) rsp_valid <= 1'b1;
        end
        ST_RD: begin
          rsp_valid <= 1'b1;
          rsp_rdata <= dec_ue ? mem_rdata[DW-1:0] : dec_fix;
          rsp_err   <= dec_ue;
          ce_pulse  <= dec_ce;
          ue_pulse  <= dec_ue;
        end
        ST_WR2: rsp_valid <= 1'b1;
        ST_MRG: begin
          rsp_valid <= 1'b1;
          rsp_err   <= dec_ue;
          ce_pulse  <= dec_ce;
          ue_pulse  <= dec_ue;
        end
        default: ;
      endcase
    end
  end

  assign fault_out = ue_pulse;
  assign ue_evt    = dec_ue && (st == ST_RD || st == ST_MRG);

  ecc_err_capture #(.IW(IW)) u_cap (
    .clk       (clk),
    .rst_n     (rst_n),
    .ue_evt    (ue_evt),
    .evt_idx   (idx_q),
    .evt_syn   (dec_syn),
    .clr       (err_clear),
    .err_valid (err_valid),
    .err_idx   (cap_idx),
    .err_syn   (err_syndrome)
  );

  assign err_addr = {cap_idx, 2'b00};

  // R1: a word write answers next cycle and leaves the channel open
  p_word_write_no_wait_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && req_write && sz == SZ_WORD) |=> (rsp_valid && req_ready));

  // R2: a read stalls one cycle, then answers
  p_read_latency_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && !req_write) |=> (!req_ready && !rsp_valid) ##1 rsp_valid);

  // R7: an uncorrectable read phase suppresses the write-back
  p_rmw_abort_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_MRG && dec_ue) |-> !mem_we);

  // R6: the fault line only accompanies an error response
  p_fault_with_err_r6: assert property (@(posedge clk) disable iff (!rst_n)
    fault_out |-> (rsp_valid && rsp_err && !ce_pulse));
endmodule

// File: tb/ecc_sram_ctrl_test.sv
`timescale 1ns/1ps
module ecc_sram_ctrl_test;
  import ecc_sram_pkg::*;
  localparam int AW = 12;
  localparam int IW = AW - 2;
  localparam int DEPTH = 1 << IW;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req_valid = 1'b0, req_write = 1'b0, err_clear = 1'b0;
  logic [1:0] req_size = 2'd2;
  logic [AW-1:0] req_addr = '0;
  logic [63:0] req_wdata = '0;
  logic [CWW-1:0] inj_mask = '0;
  logic [CWW-1:0] mem_rdata = '0;
  logic req_ready, rsp_valid, rsp_err, mem_en, mem_we;
  logic ce_pulse, ue_pulse, fault_out, err_valid;
  logic [31:0] rsp_rdata;
  logic [IW-1:0] mem_addr;
  logic [CWW-1:0] mem_wdata;
  logic [AW-1:0] err_addr;
  logic [CW-1:0] err_syndrome;

  logic [CWW-1:0] arr [DEPTH];
  logic [31:0] shadow [DEPTH];
  int n_chk = 0, n_fail = 0, cyc = 0;
  bit done = 0;
  int r_lat;
  logic r_rdy, r_err, r_ce, r_ue, r_flt;
  logic [31:0] r_data;

  always #2.5 clk = ~clk;

  ecc_sram_ctrl #(.AW(AW)) uut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_write(req_write), .req_size(req_size), .req_addr(req_addr),
    .req_wdata(req_wdata), .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata),
    .rsp_err(rsp_err), .mem_en(mem_en), .mem_we(mem_we), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .inj_mask(inj_mask),
    .ce_pulse(ce_pulse), .ue_pulse(ue_pulse), .fault_out(fault_out),
    .err_clear(err_clear), .err_valid(err_valid), .err_addr(err_addr),
    .err_syndrome(err_syndrome)
  );

  // behavioural single-port array, one-cycle read latency
  always @(posedge clk) begin
    if (mem_en) begin
      if (mem_we) arr[mem_addr] <= mem_wdata;
      else        mem_rdata <= arr[mem_addr];
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc == 150000 && !done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog (all requirements): actual hung expected finished");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  task automatic check(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] exp_merge(input logic [31:0] old, input logic [1:0] sz,
                                            input logic [1:0] lo, input logic [31:0] nw);
    logic [31:0] r;
    r = old;
    if (sz == 2'd0)      r[int'(lo)*8 +: 8] = nw[int'(lo)*8 +: 8];
    else if (sz == 2'd1) r[int'(lo[1])*16 +: 16] = nw[int'(lo[1])*16 +: 16];
    else                 r = nw;
    return r;
  endfunction

  task automatic issue(input bit wr, input logic [1:0] sz, input int addr,
                       input logic [63:0] wd, input bit clr_mid);
    @(negedge clk);
    req_valid = 1'b1; req_write = wr; req_size = sz;
    req_addr = AW'(addr); req_wdata = wd;
    @(negedge clk);
    req_valid = 1'b0;
    r_rdy = req_ready;
    r_lat = 1;
    if (clr_mid) err_clear = 1'b1;
    while (!rsp_valid && r_lat < 6) begin
      @(negedge clk);
      err_clear = 1'b0;
      r_lat++;
    end
    err_clear = 1'b0;
    r_data = rsp_rdata; r_err = rsp_err; r_ce = ce_pulse;
    r_ue = ue_pulse; r_flt = fault_out;
  endtask

  task automatic wr_word(input int idx, input logic [31:0] d);
    issue(1'b1, 2'd2, idx * 4, {32'h0, d}, 1'b0);
    shadow[idx] = d;
  endtask

  task automatic rd_word(input int idx);
    issue(1'b0, 2'd2, idx * 4, 64'h0, 1'b0);
  endtask

  task automatic pulse_clear();
    @(negedge clk); err_clear = 1'b1;
    @(negedge clk); err_clear = 1'b0;
  endtask

  initial begin
    logic [CWW-1:0] saved;
    logic [31:0] d;
    void'($urandom(32'd20240611));

    repeat (3) @(negedge clk);
    check(req_ready == 1'b1 && rsp_valid == 1'b0 && err_valid == 1'b0, "R11 reset outputs",
          {req_ready, rsp_valid, err_valid}, 3'b100);
    rst_n = 1'b1;
    @(negedge clk);
    check({ce_pulse, ue_pulse, fault_out} == 3'b000, "R11 strobes idle after reset",
          {ce_pulse, ue_pulse, fault_out}, 3'b000);

    // fill rows 0..63
    for (int i = 0; i < 64; i++) begin
      wr_word(i, $urandom);
      if (i < 4) begin
        check(r_lat == 1 && r_rdy == 1'b1, "R1 word write zero wait", {r_lat, r_rdy}, {32'd1, 1'b1});
      end
    end
    rd_word(7);
    check(r_data == shadow[7] && !r_err && !r_ce, "R2 read data", r_data, shadow[7]);
    check(r_lat == 2 && r_rdy == 1'b0, "R2 read latency", {r_lat, r_rdy}, {32'd2, 1'b0});
    issue(1'b0, 2'd0, 20 * 4 + 3, 64'h0, 1'b0);
    check(r_data == shadow[20] && r_lat == 2, "R2 size and low address ignored", r_data, shadow[20]);

    // R10: injection mask lands in the stored codeword
    d = 32'hC0FFEE11;
    wr_word(70, d);
    saved = arr[70];
    inj_mask = CWW'(1) << 35;
    wr_word(70, d);
    check((arr[70] ^ saved) == (CWW'(1) << 35), "R10 mask xored into codeword",
          arr[70] ^ saved, CWW'(1) << 35);
    inj_mask = '0;
    rd_word(70);
    check(r_data == d && r_ce && !r_err, "R5 check-bit flip corrected", {r_data, r_ce, r_err}, {d, 2'b10});

    // R5: data-bit flip corrected
    arr[3] = arr[3] ^ (CWW'(1) << 17);
    rd_word(3);
    check(r_data == shadow[3] && r_ce && !r_err && !r_ue, "R5 data flip corrected",
          {r_data, r_ce, r_err}, {shadow[3], 2'b10});
    wr_word(3, shadow[3]);

    // R8: correctable read phase during byte write
    arr[5] = arr[5] ^ CWW'(1);
    issue(1'b1, 2'd0, 5 * 4 + 2, 64'h00AB_0000, 1'b0);
    shadow[5] = exp_merge(shadow[5], 2'd0, 2'd2, 32'h00AB_0000);
    check(!r_err && r_ce && r_lat == 2 && r_rdy == 1'b0, "R8 rmw with corrected read",
          {r_err, r_ce, r_lat}, {2'b01, 32'd2});
    rd_word(5);
    check(r_data == shadow[5] && !r_ce && !r_err, "R8 merged row clean", r_data, shadow[5]);

    // R6: double flip via injection
    d = 32'h1234_5678;
    inj_mask = (CWW'(1) << 4) | (CWW'(1) << 20);
    wr_word(80, d);
    inj_mask = '0;
    rd_word(80);
    check(r_err && r_ue && r_flt && !r_ce, "R6 double flip flagged", {r_err, r_ue, r_flt, r_ce}, 4'b1110);
    check(r_data == (d ^ 32'h0010_0010), "R6 raw data returned", r_data, d ^ 32'h0010_0010);
    check(err_valid && err_addr == AW'(80 * 4) && err_syndrome != '0, "R9 capture first failure",
          err_addr, 80 * 4);

    // R6: row from the neighbouring address
    arr[8] = arr[9];
    rd_word(8);
    check(r_err && r_ue && r_flt, "R6 address mismatch flagged", {r_err, r_ue, r_flt}, 3'b111);
    check(err_addr == AW'(80 * 4), "R9 held while not cleared", err_addr, 80 * 4);

    // R9: clear in the same cycle as a new failure
    issue(1'b0, 2'd2, 8 * 4, 64'h0, 1'b1);
    check(r_err && err_valid && err_addr == AW'(8 * 4), "R9 clear with new capture", err_addr, 8 * 4);
    pulse_clear();
    check(!err_valid, "R9 clear empties capture", err_valid, 1'b0);
    wr_word(8, shadow[8]);

    // R7: uncorrectable read phase aborts write-back
    arr[10] = arr[10] ^ CWW'(6);
    saved = arr[10];
    issue(1'b1, 2'd1, 10 * 4 + 2, 64'hBEEF_0000, 1'b0);
    check(r_err && r_ue && r_flt, "R7 rmw abort response", {r_err, r_ue, r_flt}, 3'b111);
    check(arr[10] == saved, "R7 row untouched", arr[10], saved);
    check(err_valid && err_addr == AW'(10 * 4), "R9 capture after clear", err_addr, 10 * 4);
    pulse_clear();
    wr_word(10, shadow[10]);

    // R3: doubleword
    issue(1'b1, 2'd3, 12 * 4, {32'hAAAA_5555, 32'h0F0F_F0F0}, 1'b0);
    check(r_lat == 2 && r_rdy == 1'b0 && !r_err, "R3 dword timing", {r_lat, r_rdy}, {32'd2, 1'b0});
    shadow[12] = 32'h0F0F_F0F0; shadow[13] = 32'hAAAA_5555;
    rd_word(12);
    check(r_data == shadow[12], "R3 low word", r_data, shadow[12]);
    rd_word(13);
    check(r_data == shadow[13], "R3 high word", r_data, shadow[13]);

    // random mix
    for (int it = 0; it < 400; it++) begin
      int op, idx;
      logic [1:0] lo;
      logic [63:0] wd;
      op = $urandom_range(0, 4);
      idx = $urandom_range(0, 63);
      lo = 2'($urandom);
      wd = {$urandom, $urandom};
      case (op)
        0: begin
          rd_word(idx);
          check(r_data == shadow[idx] && r_lat == 2 && !r_err && !r_ce, "R2 random read",
                r_data, shadow[idx]);
        end
        1: begin
          wr_word(idx, wd[31:0]);
          check(r_lat == 1 && r_rdy && !r_err, "R1 random word write", r_lat, 1);
        end
        2, 3: begin
          logic [1:0] s;
          s = (op == 2) ? 2'd0 : 2'd1;
          if (op == 3) lo[0] = 1'b0;
          issue(1'b1, s, idx * 4 + int'(lo), wd, 1'b0);
          shadow[idx] = exp_merge(shadow[idx], s, lo, wd[31:0]);
          check(r_lat == 2 && !r_err && !r_ce, "R4 random sub-word write", r_lat, 2);
        end
        default: begin
          idx = idx & ~1;
          issue(1'b1, 2'd3, idx * 4, wd, 1'b0);
          shadow[idx] = wd[31:0]; shadow[idx + 1] = wd[63:32];
          check(r_lat == 2 && !r_err, "R3 random dword write", r_lat, 2);
        end
      endcase
    end
    for (int i = 0; i < 64; i++) begin
      rd_word(i);
      check(r_data == shadow[i] && !r_err && !r_ce, "R4 final contents", r_data, shadow[i]);
    end

    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule